// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a memory-mapped watchdog for a 32-bit register bus with separate write and read strobes, a 4-bit byte offset and a data word. Software arms it through a mode register and a timing register. Each of these accepts a write only when the write carries that register's access key in its upper bits. While the watchdog is enabled, a prescaled tick decrements a 24-bit counter. Software keeps the system alive by writing a fixed restart value, which reloads the counter.

When the counter reaches zero while enabled, the block latches a status flag. Depending on the enable bits, it also emits a reset pulse of programmable length, raises an interrupt level, or does both. Clock generation, bus bridging and software are outside the block.

Top module: `wdt_keyed`

## Requirements
- R1: After a synchronous active-low reset, both outputs are low. Reading offset 0x0 returns 0, offset 0x4 returns 0x00003FFF (reload field 0xFFF, prescale code 3), and offset 0xC returns 0.
- R2: A write to offset 0x0 updates the mode register only when wdata[23:12] is 0xABC. With any other key the write has no effect.
- R3: In the mode register, bit 0 enables counting, bit 1 enables the reset pulse and bit 2 enables the interrupt. Bits [6:4] form a pulse-length code: codes 0, 1 and 2 give 2, 4 and 8 cycles, and any code of 3 or more gives 16 cycles.
- R4: A write to offset 0x4 is accepted only when wdata[25:14] is 0x248. Bits [13:2] then set the 12-bit reload field and bits [1:0] the prescale code. A write with any other key has no effect.
- R5: Prescale codes 0, 1, 2 and 3 give one counter tick every 8, 64, 512 and 4096 bus cycles. The prescaler restarts from zero on a restart write and while the watchdog is disabled.
- R6: A write of exactly 0x00001999 to offset 0x8 loads the counter with reload*4096 + 4095, restarts the prescaler and clears the status flag. A write of any other value to 0x8 has no effect.
- R7: When a tick takes the enabled counter from 1 to 0, status bit 0 is set. The bit stays set, and the counter stays at zero, until the next restart.
- R8: At that expiry, if the reset enable is set, rst_pulse_o goes high on the following cycle and stays high for exactly the coded length.
- R9: irq_o is high exactly while the status flag and the interrupt enable are both set.
- R10: While the enable bit is clear, the counter does not move and no expiry occurs.
- R11: Reads return the stored fields with every key bit reading as zero. Offset 0x8 reads as zero. Offset 0xC is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Byte offset of the register |
| wdata | input | 32 | Write data, including the key |
| rdata | output | 32 | Read data, valid in the cycle rd_en is high |
| rst_pulse_o | output | 1 | Timed reset pulse raised on expiry |
| irq_o | output | 1 | Interrupt level raised on expiry |

## Verification
The main function is exercised with three expiry patterns, all using the fastest prescale and a zero reload field.

- **Short pulse.** A run in short-pulse mode takes a wrong restart value midway. This separates a correct restart decode from a loose one, because the timeout must still land 32760 cycles after the real restart.
- **Interrupt with pause.** A run in interrupt mode is paused by a keyed disable. Expiry must come late by at least the pause, and the interrupt level must hold until a restart.
- **Long pulse with early restart.** A run in long-pulse mode takes an early genuine restart and a badly keyed disable attempt. Only the first may move the deadline, and the pulse must last 16 cycles.

A behavioural model in the bench follows every cycle of both outputs. Read-back checks cover the keyed and unkeyed writes to each register.

// File: rtl/wdt_pkg.sv
// Package: wdt_pkg
// Shared widths, access keys, register offsets and field types for the
// keyed watchdog. Assumes a 32-bit bus with byte offsets in a 4-bit field.
package wdt_pkg;

    localparam int REG_W         = 32;
    localparam int ADDR_W        = 4;
    localparam int CNT_W         = 24;
    localparam int RLD_W         = 12;
    localparam int LOW_W         = CNT_W - RLD_W;
    localparam int PSEL_W        = 2;
    localparam int LEN_CODE_W    = 3;
    localparam int KEY_W         = 12;
    localparam int PRE_BASE_LOG  = 3;
    localparam int PRE_STEP_LOG  = 3;
    localparam int PRE_W         = PRE_BASE_LOG + PRE_STEP_LOG * ((1 << PSEL_W) - 1) + 1;
    localparam int LEN_STEPS     = 4;
    localparam int PULSE_W       = LEN_STEPS + 1;

    localparam int ZMR_KEY_LSB   = 12;
    localparam int CCR_KEY_LSB   = 14;
    localparam logic [KEY_W-1:0] ZMR_KEY     = 12'hABC;
    localparam logic [KEY_W-1:0] CCR_KEY     = 12'h248;
    localparam logic [REG_W-1:0] RESTART_KEY = 32'h0000_1999;

    localparam logic [ADDR_W-1:0] OFS_MODE    = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_TIMING  = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_RESTART = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 4'hC;

    typedef struct packed {
        logic [LEN_CODE_W-1:0] len;
        logic                  irq_en;
        logic                  rst_en;
        logic                  en;
    } mode_t;

    typedef struct packed {
        logic [RLD_W-1:0]  rld;
        logic [PSEL_W-1:0] psel;
    } timing_t;

    // Last prescaler count before a tick for a given prescale code.
    function automatic logic [PRE_W-1:0] pre_last(input logic [PSEL_W-1:0] psel);
        return (PRE_W'(1) << (PRE_BASE_LOG + PRE_STEP_LOG * int'(psel))) - PRE_W'(1);
    endfunction

    // Reset pulse length in cycles for a length code.
    function automatic logic [PULSE_W-1:0] pulse_len(input logic [LEN_CODE_W-1:0] code);
        if (int'(code) >= LEN_STEPS - 1)
            return PULSE_W'(1) << LEN_STEPS;
        return PULSE_W'(1) << (int'(code) + 1);
    endfunction

endpackage

// File: rtl/wdt_regs.sv
// Module: wdt_regs
// Key-checked register file. It stores the mode and timing fields only for
// writes that carry the matching key, decodes the restart value, and
// returns read data with the key bits as zero. Assumes single-cycle strobes.
module wdt_regs
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              sts,
    output mode_t             mode_q,
    output timing_t           timing_q,
    output logic              restart_hit,
    output logic [REG_W-1:0]  rdata
);

    logic mode_hit;
    logic timing_hit;

    // Decode keyed writes and the exact restart value.
    always_comb begin
        mode_hit    = wr_en && (addr == OFS_MODE)
                      && (wdata[ZMR_KEY_LSB +: KEY_W] == ZMR_KEY);
        timing_hit  = wr_en && (addr == OFS_TIMING)
                      && (wdata[CCR_KEY_LSB +: KEY_W] == CCR_KEY);
        restart_hit = wr_en && (addr == OFS_RESTART) && (wdata == RESTART_KEY);
    end

    // Mode register: updated only by a correctly keyed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (mode_hit) begin
            mode_q.en     <= wdata[0];
            mode_q.rst_en <= wdata[1];
            mode_q.irq_en <= wdata[2];
            mode_q.len    <= wdata[4 +: LEN_CODE_W];
        end
    end

    // Timing register: reload field and prescale code, keyed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timing_q.rld  <= '1;
            timing_q.psel <= '1;
        end else if (timing_hit) begin
            timing_q.rld  <= wdata[PSEL_W +: RLD_W];
            timing_q.psel <= wdata[PSEL_W-1:0];
        end
    end

    // Read multiplexer: stored fields only, keys read as zero.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                OFS_MODE:   rdata = REG_W'({mode_q.len, 1'b0, mode_q.irq_en,
                                            mode_q.rst_en, mode_q.en});
                OFS_TIMING: rdata = REG_W'({timing_q.rld, timing_q.psel});
                OFS_STATUS: rdata = REG_W'(sts);
                default:    rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/wdt_prescaler.sv
// Module: wdt_prescaler
// Divides the bus clock by 8, 64, 512 or 4096 according to the prescale
// code and emits a one-cycle tick. It clears on restart and while stopped.
module wdt_prescaler
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              clear,
    input  logic [PSEL_W-1:0] psel,
    output logic              tick
);

    logic [PRE_W-1:0] pre_q;
    logic             at_last;

    // Terminal count reached; >= also covers a code change to a shorter limit.
    always_comb begin
        at_last = (pre_q >= pre_last(psel));
        tick    = run && at_last;
    end

    // Prescale counter: count up, wrap at the limit, clear when idle or restarted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_q <= '0;
        else if (!run || clear || at_last)
            pre_q <= '0;
        else
            pre_q <= pre_q + PRE_W'(1);
    end

endmodule

// File: rtl/wdt_counter.sv
// Module: wdt_counter
// 24-bit down-counter with a sticky expiry flag, a timed reset pulse and an
// interrupt level. Assumes tick is a single-cycle strobe from the prescaler.
module wdt_counter
    import wdt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  reload,
    input  logic [RLD_W-1:0]      rld,
    input  logic                  rst_en,
    input  logic                  irq_en,
    input  logic [LEN_CODE_W-1:0] len,
    output logic [CNT_W-1:0]      cnt_q,
    output logic                  sts_q,
    output logic                  expire,
    output logic                  rst_pulse_o,
    output logic                  irq_o
);

    logic [PULSE_W-1:0] pulse_q;

    // An expiry is the tick that moves the count from one to zero; restart wins.
    always_comb begin
        expire      = tick && (cnt_q == CNT_W'(1)) && !reload;
        rst_pulse_o = (pulse_q != '0);
        irq_o       = sts_q && irq_en;
    end

    // Down-counter: reload with the field as upper bits, low bits all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '1;
        else if (reload)
            cnt_q <= {rld, {LOW_W{1'b1}}};
        else if (tick && (cnt_q != '0))
            cnt_q <= cnt_q - CNT_W'(1);
    end

    // Sticky status flag: set on expiry, cleared by restart.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sts_q <= 1'b0;
        else if (reload)
            sts_q <= 1'b0;
        else if (expire)
            sts_q <= 1'b1;
    end

    // Reset pulse timer: loaded with the coded length, counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_q <= '0;
        else if (expire && rst_en)
            pulse_q <= pulse_len(len);
        else if (pulse_q != '0)
            pulse_q <= pulse_q - PULSE_W'(1);
    end

endmodule

// File: rtl/wdt_keyed.sv
// Module: wdt_keyed
// Top of the key-protected watchdog: register file, prescaler and counter.
// Assumes one bus clock for the bus and the count, with synchronous reset.
module wdt_keyed
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [3:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              rst_pulse_o,
    output logic              irq_o
);

    mode_t            mode_q;
    timing_t          timing_q;
    logic             restart_hit;
    logic             tick;
    logic             expire;
    logic             sts_q;
    logic [CNT_W-1:0] cnt_q;

    wdt_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .wdata       (wdata),
        .sts         (sts_q),
        .mode_q      (mode_q),
        .timing_q    (timing_q),
        .restart_hit (restart_hit),
        .rdata       (rdata)
    );

    wdt_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (mode_q.en),
        .clear (restart_hit),
        .psel  (timing_q.psel),
        .tick  (tick)
    );

    wdt_counter u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .reload      (restart_hit),
        .rld         (timing_q.rld),
        .rst_en      (mode_q.rst_en),
        .irq_en      (mode_q.irq_en),
        .len         (mode_q.len),
        .cnt_q       (cnt_q),
        .sts_q       (sts_q),
        .expire      (expire),
        .rst_pulse_o (rst_pulse_o),
        .irq_o       (irq_o)
    );

endmodule

// File: rtl/wdt_keyed_chk.sv
// Module: wdt_keyed_chk
// Temporal checks on the watchdog, bound into every wdt_keyed instance.
module wdt_keyed_chk
    import wdt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [3:0]       addr,
    input logic [31:0]      wdata,
    input logic [5:0]       mode_bits,
    input logic             restart_hit,
    input logic [CNT_W-1:0] cnt_q,
    input logic             sts_q,
    input logic             expire,
    input logic             rst_pulse_o,
    input logic             irq_o
);

    logic mode_keyed;
    logic mode_bad_key;

    // Port-level view of mode writes, with and without the key.
    always_comb begin
        mode_keyed   = wr_en && (addr == OFS_MODE) && (wdata[23:12] == ZMR_KEY);
        mode_bad_key = wr_en && (addr == OFS_MODE) && (wdata[23:12] != ZMR_KEY);
    end

    p_bad_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_bad_key |=> $stable(mode_bits));

    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restart_hit |=> ((cnt_q[LOW_W-1:0] == {LOW_W{1'b1}}) && !sts_q));

    p_sts_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q && !restart_hit) |=> sts_q);

    p_zero_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_q == '0) && !restart_hit) |=> (cnt_q == '0));

    p_pulse_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && mode_bits[1]) |=> rst_pulse_o);

    p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !restart_hit && !mode_keyed) |=> irq_o);

    p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_bits[0] && !restart_hit) |=> $stable(cnt_q));

endmodule

bind wdt_keyed wdt_keyed_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .mode_bits   (mode_q),
    .restart_hit (restart_hit),
    .cnt_q       (cnt_q),
    .sts_q       (sts_q),
    .expire      (expire),
    .rst_pulse_o (rst_pulse_o),
    .irq_o       (irq_o)
);

// File: tb/wdt_keyed_tb.sv
// Bench for wdt_keyed: a behavioural reference model compared on every
// clock, plus directed timing and read-back checks.
module wdt_keyed_tb;

    localparam int CLK_PERIOD = 10;
    localparam int FULL_RUN   = 32760;   // 4095 ticks of 8 cycles

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rst_pulse_o;
    logic        irq_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    wdt_keyed u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .wdata       (wdata),
        .rdata       (rdata),
        .rst_pulse_o (rst_pulse_o),
        .irq_o       (irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic void chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h at cycle %0d", req, act, exp, cyc);
        end
    endfunction

    // ---------------- behavioural reference model ----------------
    int m_pre = 0, m_cnt = 0, m_pulse = 0, m_len = 0, m_crv = 0, m_psel = 0;
    bit m_en = 0, m_rsten = 0, m_irqen = 0, m_sts = 0;

    function automatic int plen(input int code);
        return (code >= 3) ? 16 : (2 << code);
    endfunction

    always @(posedge clk) begin : ref_model
        int lim;
        bit tk, rs, ex;
        if (!rst_n) begin
            m_pre = 0; m_cnt = 24'hFFFFFF; m_pulse = 0; m_len = 0;
            m_crv = 4095; m_psel = 3; m_en = 0; m_rsten = 0; m_irqen = 0; m_sts = 0;
        end else begin
            lim = (8 << (3 * m_psel)) - 1;
            tk  = m_en && (m_pre >= lim);
            rs  = wr_en && (addr == 4'h8) && (wdata == 32'h0000_1999);
            ex  = tk && (m_cnt == 1) && !rs;
            if (!m_en || rs || tk) m_pre = 0; else m_pre++;
            if (ex && m_rsten) m_pulse = plen(m_len);
            else if (m_pulse > 0) m_pulse--;
            if (rs) m_sts = 0; else if (ex) m_sts = 1;
            if (rs) m_cnt = m_crv * 4096 + 4095;
            else if (tk && m_cnt > 0) m_cnt--;
            if (wr_en && addr == 4'h0 && wdata[23:12] == 12'hABC) begin
                m_en = wdata[0]; m_rsten = wdata[1]; m_irqen = wdata[2];
                m_len = int'(wdata[6:4]);
            end
            if (wr_en && addr == 4'h4 && wdata[25:14] == 12'h248) begin
                m_crv = int'(wdata[13:2]); m_psel = int'(wdata[1:0]);
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            4'h0: return 32'((m_len << 4) | (int'(m_irqen) << 2) | (int'(m_rsten) << 1) | int'(m_en));
            4'h4: return 32'((m_crv << 2) | m_psel);
            4'hC: return 32'(m_sts);
            default: return 32'h0;
        endcase
    endfunction

    // Per-cycle comparison of both outputs against the model (R8, R9).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R8 pulse vs model", 32'(rst_pulse_o), 32'(m_pulse != 0));
            chk("R9 irq vs model", 32'(irq_o), 32'(m_sts && m_irqen));
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        chk(req, rdata, exp);
        chk({req, " model"}, rdata, m_read(a));
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin : main
        int t0, dt, w;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 pulse low", 32'(rst_pulse_o), 32'h0);
        chk("R1 irq low", 32'(irq_o), 32'h0);
        rd_chk("R1 mode", 4'h0, 32'h0);
        rd_chk("R1 timing", 4'h4, 32'h0000_3FFF);
        rd_chk("R1 status", 4'hC, 32'h0);

        // R2: badly keyed mode write dropped; R11: status is read-only
        wr(4'h0, 32'h00AB_B007);
        rd_chk("R2 bad key mode", 4'h0, 32'h0);
        wr(4'hC, 32'hFFFF_FFFF);
        rd_chk("R11 status read-only", 4'hC, 32'h0);

        // R4 / R11: timing key check and key bits reading zero
        wr(4'h4, 32'h0091_0000);
        rd_chk("R4 bad key timing", 4'h4, 32'h0000_3FFF);
        wr(4'h4, 32'h0092_2AF2);
        rd_chk("R4 timing fields", 4'h4, 32'h0000_2AF2);
        wr(4'h4, 32'h0092_0000);
        rd_chk("R4 timing zero", 4'h4, 32'h0);
        rd_chk("R11 restart reads zero", 4'h8, 32'h0);

        // R3: mode fields read back with the key as zero
        wr(4'h0, 32'h00AB_C003);
        rd_chk("R3 mode fields", 4'h0, 32'h0000_0003);

        // Run 1: short pulse, wrong restart value midway (R5, R6, R7, R8)
        wr(4'h8, 32'h0000_1999);
        t0 = cyc;
        idle(16000);
        wr(4'h8, 32'h0000_1998);
        while (!rst_pulse_o) @(negedge clk);
        dt = cyc - t0;
        chk("R6 wrong restart ignored / R5 timing", 32'(dt), 32'(FULL_RUN));
        w = 0;
        while (rst_pulse_o) begin w++; @(negedge clk); end
        chk("R8 pulse length code 0", 32'(w), 32'd2);
        rd_chk("R7 status set", 4'hC, 32'h1);
        idle(40);
        rd_chk("R7 status sticky", 4'hC, 32'h1);

        // Run 2: interrupt mode with a disabled pause (R9, R10, R6)
        wr(4'h0, 32'h00AB_C005);
        wr(4'h8, 32'h0000_1999);
        rd_chk("R6 restart clears status", 4'hC, 32'h0);
        t0 = cyc;
        idle(1000);
        wr(4'h0, 32'h00AB_C004);
        idle(3000);
        chk("R10 no expiry while disabled", 32'(irq_o), 32'h0);
        wr(4'h0, 32'h00AB_C005);
        while (!irq_o) @(negedge clk);
        dt = cyc - t0;
        chk("R10 pause delays expiry", 32'(dt >= FULL_RUN + 3000), 32'h1);
        idle(50);
        chk("R9 irq level held", 32'(irq_o), 32'h1);
        chk("R8 no pulse when reset disabled", 32'(rst_pulse_o), 32'h0);
        wr(4'h8, 32'h0000_1999);
        chk("R9 irq cleared by restart", 32'(irq_o), 32'h0);

        // Run 3: long pulse, early restart, badly keyed disable (R2, R6, R8)
        wr(4'h0, 32'h00AB_C033);
        wr(4'h8, 32'h0000_1999);
        idle(10000);
        wr(4'h8, 32'h0000_1999);
        t0 = cyc;
        wr(4'h0, 32'h00AB_D032);
        while (!rst_pulse_o) @(negedge clk);
        dt = cyc - t0;
        chk("R6 early restart / R2 bad key disable", 32'(dt), 32'(FULL_RUN));
        w = 0;
        while (rst_pulse_o) begin w++; @(negedge clk); end
        chk("R8 pulse length code 3", 32'(w), 32'd16);
        chk("R9 irq stays low", 32'(irq_o), 32'h0);

        finish_run();
    end

endmodule